// File: doc/BRIEF.md
# Transmit Dominant Timeout Guard

This block sits between the transmit data line of a bus protocol controller and the enable of the low-side driver of a single-wire bus transceiver. A low transmit level pulls the bus to its dominant state. A high level leaves the driver off, so the bus stays recessive. The guard times how long the transmit input stays low. If the low lasts past a set limit, it latches a forced-recessive state. A stuck or disconnected controller therefore cannot hold the bus dominant.

The latch does not clear on a rising edge. It clears only after the input has stayed high for a qualified interval, and any low sample during that interval restarts the count. Time is measured in ticks of an external timebase. The defaults assume a 1 µs tick: a 9 ms dominant limit and a release that needs more than 10 µs of high level. The driver can be enabled only while the normal-mode qualifier is high.

Top module: `txdom_guard`

## Requirements
- R1: With `normalMode` high and no timeout latched, `drvOn` is 1 while the synchronised `txData` is low and 0 while it is high. The input passes through two flip-flops, so `drvOn` follows a change of `txData` two clock edges later.
- R2: When the synchronised `txData` has been sampled low on `DOM_TICKS` ticks in a row, `timedOut` rises on the next clock edge and `drvOn` goes to 0 while `txData` remains low.
- R3: A rising edge of `txData` does not clear `timedOut`. High intervals shorter than the release qualification are discarded whenever a low sample occurs, and they do not add up.
- R4: While timed out, `timedOut` clears once the synchronised `txData` has been high on `REARM_TICKS`+1 consecutive ticks. After that, a low input drives `drvOn` to 1 again.
- R5: While `normalMode` is 0, `drvOn` is 0 whatever the value of `txData`. Low-duration timing continues in any mode, so a permanently low input (a floating pin pulled low) sets `timedOut` even outside normal mode.
- R6: Whenever `timedOut` is 1, `drvOn` is 0.
- R7: A single high sample clears the low-duration count. Separate low pulses, each shorter than the limit, never trip the timeout.
- R8: Both duration counts advance only in cycles where `tick` is 1. Without ticks, a held low never trips the timeout and a held high never releases it.
- R9: Reset clears `timedOut` and both counts, and it sets the synchroniser to the recessive (high) level. As a result `drvOn` is 0 out of reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timebase strobe, one clock wide |
| txData | input | 1 | Transmit data from the controller, low = dominant |
| normalMode | input | 1 | High when the transceiver is in normal mode |
| drvOn | output | 1 | Bus driver enable, 1 = drive dominant |
| timedOut | output | 1 | 1 while the driver is forced recessive |

## Verification
The bench holds the input low for just under the limit and then just over it. This exposes an off-by-several threshold, or a low count that survives a high sample and lets short pulses add up to a false trip. Once timed out, it sends several high blips, each shorter than the release interval and separated by lows. A design that clears on a rising edge, or that adds up high time across lows, would release too early. It also stops the timebase, to show that counting is gated by `tick`, and it trips the timeout with normal mode off, to show that a floating input is caught before the controller enables transmission.

// File: rtl/txguard_pkg.sv
package txguard_pkg;

  // strobes from control to the duration counters
  typedef struct packed {
    logic lowRun;
    logic lowClr;
    logic highRun;
    logic highClr;
  } txgStrobe_t;

endpackage

// File: rtl/txg_sync.sv
module txg_sync #(
  parameter int STAGES = 2,
  parameter bit RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] stageQ;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stageQ[i] <= RESET_VAL;
          else        stageQ[i] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stageQ[i] <= RESET_VAL;
          else        stageQ[i] <= stageQ[i-1];
        end
      end
    end
  endgenerate

  assign dout = stageQ[STAGES-1];

endmodule

// File: rtl/txg_timers.sv
module txg_timers
  import txguard_pkg::*;
#(
  parameter int DOM_TICKS   = 9000,
  parameter int REARM_TICKS = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  txgStrobe_t strobe,
  output logic       lowAtLimit,
  output logic       highQual
);

  localparam int HIGH_TICKS = REARM_TICKS + 1;
  localparam int LOW_W  = $clog2(DOM_TICKS + 1);
  localparam int HIGH_W = $clog2(HIGH_TICKS + 1);
  localparam logic [LOW_W-1:0]  LOW_MAX  = LOW_W'(DOM_TICKS);
  localparam logic [HIGH_W-1:0] HIGH_MAX = HIGH_W'(HIGH_TICKS);

  logic [LOW_W-1:0]  lowCnt;
  logic [HIGH_W-1:0] highCnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              lowCnt <= '0;
    else if (strobe.lowClr)                  lowCnt <= '0;
    else if (strobe.lowRun && lowCnt < LOW_MAX) lowCnt <= lowCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  highCnt <= '0;
    else if (strobe.highClr)                     highCnt <= '0;
    else if (strobe.highRun && highCnt < HIGH_MAX) highCnt <= highCnt + 1'b1;
  end

  assign lowAtLimit = (lowCnt == LOW_MAX);
  assign highQual   = (highCnt == HIGH_MAX);

  // R2: the low count saturates and never passes the limit
  a_r2_low_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    lowCnt <= LOW_MAX);

  // R7: a clear request empties the low count on the next edge
  a_r7_low_clears: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.lowClr |=> lowCnt == '0);

  // R8: without a tick the counts can only hold or clear
  a_r8_tick_gates_low: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> (lowCnt == $past(lowCnt) || lowCnt == '0));
  a_r8_tick_gates_high: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> (highCnt == $past(highCnt) || highCnt == '0));

endmodule

// File: rtl/txg_ctrl.sv
module txg_ctrl
  import txguard_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       txSync,
  input  logic       lowAtLimit,
  input  logic       highQual,
  output txgStrobe_t strobe,
  output logic       timedOut
);

  always_comb begin
    strobe.lowClr  = txSync;
    strobe.lowRun  = tick & ~txSync;
    strobe.highClr = ~timedOut | ~txSync;
    strobe.highRun = tick & txSync & timedOut;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    timedOut <= 1'b0;
    else if (timedOut && highQual) timedOut <= 1'b0;
    else if (lowAtLimit)           timedOut <= 1'b1;
  end

  // R2: reaching the limit latches the timeout
  a_r2_trip: assert property (@(posedge clk) disable iff (!rst_n)
    (lowAtLimit && !timedOut) |=> timedOut);

  // R2: the flag rises only after the limit was reached
  a_r2_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timedOut) |-> $past(lowAtLimit));

  // R3: the latch holds until the release is qualified
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (timedOut && !highQual) |=> timedOut);

  // R4: release only after a qualified high interval
  a_r4_release_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(timedOut) |-> $past(highQual));

endmodule

// File: rtl/txdom_guard.sv
module txdom_guard
  import txguard_pkg::*;
#(
  parameter int DOM_TICKS   = 9000,
  parameter int REARM_TICKS = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic txData,
  input  logic normalMode,
  output logic drvOn,
  output logic timedOut
);

  logic       txSync;
  logic       lowAtLimit;
  logic       highQual;
  txgStrobe_t strobe;

  txg_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(txData), .dout(txSync)
  );

  txg_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .tick(tick), .txSync(txSync),
    .lowAtLimit(lowAtLimit), .highQual(highQual),
    .strobe(strobe), .timedOut(timedOut)
  );

  txg_timers #(.DOM_TICKS(DOM_TICKS), .REARM_TICKS(REARM_TICKS)) u_timers (
    .clk(clk), .rst_n(rst_n), .tick(tick), .strobe(strobe),
    .lowAtLimit(lowAtLimit), .highQual(highQual)
  );

  assign drvOn = normalMode & ~txSync & ~timedOut;

  // R6: a latched timeout keeps the driver off
  a_r6_forced_off: assert property (@(posedge clk) disable iff (!rst_n)
    timedOut |-> !drvOn);

  // R1: a driven bus traces back to a low input two edges earlier
  a_r1_sync_latency: assert property (@(posedge clk) disable iff (!rst_n)
    drvOn |-> !$past(txData, 2));

endmodule

// File: tb/txdom_guard_bench.sv
module txdom_guard_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DOM   = 20;
  localparam int REARM = 5;
  localparam int DIV   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic txData = 1'b1;
  logic normalMode = 1'b0;
  logic tickEn = 1'b1;
  logic drvOn, timedOut;

  int tests = 0;
  int fails = 0;
  int divCnt = 0;
  bit done = 1'b0;

  typedef struct {
    logic  expDrv;
    logic  expTo;
    string req;
  } expItem_t;

  expItem_t expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  txdom_guard #(.DOM_TICKS(DOM), .REARM_TICKS(REARM)) u_txdom_guard (
    .clk(clk), .rst_n(rst_n), .tick(tick), .txData(txData),
    .normalMode(normalMode), .drvOn(drvOn), .timedOut(timedOut)
  );

  // timebase: one tick every DIV clocks while enabled
  always @(posedge clk) begin
    divCnt <= (divCnt == DIV-1) ? 0 : divCnt + 1;
    tick   <= tickEn && (divCnt == DIV-1);
  end

  // monitor: pops expectations and compares away from the edge
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      expItem_t it;
      it = expQ.pop_front();
      tests++;
      if (drvOn !== it.expDrv || timedOut !== it.expTo) begin
        fails++;
        $display("FAIL %s: actual drvOn=%b timedOut=%b expected drvOn=%b timedOut=%b",
                 it.req, drvOn, timedOut, it.expDrv, it.expTo);
      end
    end
  end

  task automatic waitClk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expectNow(input logic d, input logic t, input string req);
    expItem_t it;
    it.expDrv = d; it.expTo = t; it.req = req;
    expQ.push_back(it);
    @(negedge clk);
    #1;
  endtask

  initial begin
    waitClk(3);
    // R9: reset state
    expectNow(1'b0, 1'b0, "R9 reset");
    rst_n = 1'b1;
    waitClk(2);
    expectNow(1'b0, 1'b0, "R9 after reset release");

    // R1: pass-through with sync latency
    normalMode = 1'b1;
    txData = 1'b0;
    waitClk(1);
    expectNow(1'b0, 1'b0, "R1 one edge after low");
    waitClk(1);
    expectNow(1'b1, 1'b0, "R1 two edges after low");
    txData = 1'b1;
    waitClk(3);
    expectNow(1'b0, 1'b0, "R1 high releases bus");

    // R5: outside normal mode the driver stays off
    normalMode = 1'b0;
    txData = 1'b0;
    waitClk(4);
    expectNow(1'b0, 1'b0, "R5 low outside normal mode");
    normalMode = 1'b1;
    expectNow(1'b1, 1'b0, "R5 normal mode re-enables");
    txData = 1'b1;
    waitClk(8);

    // R7: separate sub-limit lows do not add up
    for (int k = 0; k < 3; k++) begin
      txData = 1'b0;
      waitClk((DOM-3)*DIV);
      expectNow(1'b1, 1'b0, "R7 sub-limit low");
      txData = 1'b1;
      waitClk(4);
    end

    // R2/R6: long low trips the guard
    txData = 1'b0;
    waitClk((DOM-3)*DIV);
    expectNow(1'b1, 1'b0, "R2 below limit");
    waitClk(6*DIV);
    expectNow(1'b0, 1'b1, "R2 past limit");
    waitClk(10*DIV);
    expectNow(1'b0, 1'b1, "R6 still forced off while low");

    // R3: short high blips separated by lows never release
    for (int k = 0; k < 4; k++) begin
      txData = 1'b1;
      waitClk((REARM-2)*DIV);
      expectNow(1'b0, 1'b1, "R3 short high blip");
      txData = 1'b0;
      waitClk(2*DIV);
      expectNow(1'b0, 1'b1, "R3 low after blip");
    end

    // R8: no tick, no release
    tickEn = 1'b0;
    txData = 1'b1;
    waitClk(20*DIV);
    expectNow(1'b0, 1'b1, "R8 held high without ticks");
    tickEn = 1'b1;

    // R4: qualified high releases, driver re-armed
    waitClk((REARM+4)*DIV);
    expectNow(1'b0, 1'b0, "R4 released after qualified high");
    txData = 1'b0;
    waitClk(2);
    expectNow(1'b1, 1'b0, "R4 driver re-armed");

    // R8: no tick, no trip
    tickEn = 1'b0;
    waitClk((DOM+10)*DIV);
    expectNow(1'b1, 1'b0, "R8 held low without ticks");
    tickEn = 1'b1;
    txData = 1'b1;
    waitClk(4);

    // R5: floating (low) input trips even outside normal mode
    normalMode = 1'b0;
    txData = 1'b0;
    waitClk((DOM+4)*DIV);
    expectNow(1'b0, 1'b1, "R5 floating input trips in non-normal mode");
    normalMode = 1'b1;
    expectNow(1'b0, 1'b1, "R6 forced off on entry to normal mode");

    // R9: reset while timed out
    rst_n = 1'b0;
    waitClk(1);
    expectNow(1'b0, 1'b0, "R9 reset clears timeout");
    txData = 1'b1;
    rst_n = 1'b1;
    waitClk(3);
    expectNow(1'b0, 1'b0, "R9 idle after reset");

    waitClk(2);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog (R1..): actual=hung expected=complete");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule